// File: doc/BRIEF.md
# Operand Specifier Address Generator

This block resolves one operand specifier of a memory-to-memory core in one step. It takes an addressing-mode code, a register number, a constant field, a datum-size code and an optional index term. It reads the named register through a read port into the core's sixteen-entry register file. It returns one of two results: the operand itself, for the register and constant modes, or the effective address that a later stage will use to reach memory.

Two modes also move the pointer they read. The post-step mode reads through the register and then advances it by the datum size. The pre-step mode first moves the register back by the datum size and then reads through the new value. For either mode the block issues a write-back request carrying the register number and its new value. With the stack pointer as the register, the pre-step mode acts as a push and the post-step mode acts as a pop. When the index term is enabled, it is scaled by the datum size and added to the address of any memory mode.

All results are registered, so they appear one clock after the request.

Top module: `opspec_agen`

## Requirements
- R1: While reset is held, and after it is released with no request, `resValid` and `wbValid` are 0.
- R2: Mode code 0 (register) returns the contents of register `regSel` on `resValue`, with `memRef`=0 and `wbValid`=0.
- R3: Mode code 1 (constant) returns `constVal` on `resValue`, with `memRef`=0 and `wbValid`=0.
- R4: Mode code 2 (register-indirect) returns the address equal to the register contents, with `memRef`=1 and `wbValid`=0.
- R5: Mode code 3 (offset) returns the register contents plus `constVal`, modulo 2^32, with `memRef`=1 and `wbValid`=0.
- R6: Mode code 4 (post-step) returns the old register value as the address. It sets `wbValid`=1 with `wbReg`=`regSel` and `wbData` equal to the old value plus the datum size.
- R7: Mode code 5 (pre-step) returns the register value minus the datum size as the address. It sets `wbValid`=1 with `wbReg`=`regSel` and `wbData` equal to that same value. With `regSel`=14 this is a push, and mode 4 with `regSel`=14 is a pop.
- R8: `sizeSel` 0, 1, 2 and 3 select a datum size of 1, 2, 4 and 8 bytes respectively.
- R9: With `idxEn`=1, modes 2 to 5 add `idxVal` shifted left by `sizeSel` to the address. The write-back value is unaffected. Modes 0 and 1 ignore the index.
- R10: Results appear on the clock edge after the one that sampled `reqValid`. `resValid` and `wbValid` last exactly one cycle per request, so back-to-back requests give back-to-back results.
- R11: Mode codes 6 and 7 are reserved. A request with either code leaves `resValid` and `wbValid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Specifier request strobe |
| modeSel | input | 3 | Addressing-mode code |
| regSel | input | 4 | Register number |
| constVal | input | 32 | Offset or constant field |
| sizeSel | input | 2 | Datum-size code |
| idxEn | input | 1 | Apply index term |
| idxVal | input | 32 | Index register value |
| rfAddr | output | 4 | Register-file read address |
| rfData | input | 32 | Register-file read data |
| resValid | output | 1 | Result strobe |
| resValue | output | 32 | Operand value or effective address |
| memRef | output | 1 | Result is an address to access |
| wbValid | output | 1 | Side-effect write-back request |
| wbReg | output | 4 | Write-back register number |
| wbData | output | 32 | Write-back value |

## Verification
A faulty mode decode shows at the ports one cycle after the request. It appears as a wrong `memRef` flag, a missing or spurious write-back, or an address offset by exactly one datum size. Each mode is therefore driven with sizes and registers that make these offsets distinct. Errors in the step and scale arithmetic show as a value off by a power of two on the first request that uses that size code. A stuck or lingering strobe shows in the cycle after a request. That cycle is checked with reserved codes and with back-to-back requests.

// File: rtl/opspec_pkg.sv
package opspec_pkg;
  typedef enum logic [2:0] {
    MODE_REG    = 3'd0,
    MODE_CONST  = 3'd1,
    MODE_IND    = 3'd2,
    MODE_OFFSET = 3'd3,
    MODE_POST   = 3'd4,
    MODE_PRE    = 3'd5
  } specMode_e;

  typedef struct packed {
    logic legal;
    logic passReg;
    logic passConst;
    logic addConst;
    logic stepUp;
    logic stepDown;
    logic memory;
  } specCtrl_t;
endpackage

// File: rtl/opspec_ctrl.sv
module opspec_ctrl
  import opspec_pkg::*;
(
  input  logic [2:0] modeSel,
  output specCtrl_t  ctrl
);
  always_comb begin
    ctrl = '0;
    case (modeSel)
      MODE_REG:    begin ctrl.legal = 1'b1; ctrl.passReg = 1'b1; end
      MODE_CONST:  begin ctrl.legal = 1'b1; ctrl.passConst = 1'b1; end
      MODE_IND:    begin ctrl.legal = 1'b1; ctrl.memory = 1'b1; end
      MODE_OFFSET: begin ctrl.legal = 1'b1; ctrl.memory = 1'b1; ctrl.addConst = 1'b1; end
      MODE_POST:   begin ctrl.legal = 1'b1; ctrl.memory = 1'b1; ctrl.stepUp = 1'b1; end
      MODE_PRE:    begin ctrl.legal = 1'b1; ctrl.memory = 1'b1; ctrl.stepDown = 1'b1; end
      default:     ctrl = '0;
    endcase
  end
endmodule

// File: rtl/opspec_dp.sv
module opspec_dp
  import opspec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  specCtrl_t         ctrl,
  input  logic [REG_W-1:0]  regSel,
  input  logic [DATA_W-1:0] rfData,
  input  logic [DATA_W-1:0] constVal,
  input  logic [SIZE_W-1:0] sizeSel,
  input  logic              idxEn,
  input  logic [DATA_W-1:0] idxVal,
  output logic              resValid,
  output logic [DATA_W-1:0] resValue,
  output logic              memRef,
  output logic              wbValid,
  output logic [REG_W-1:0]  wbReg,
  output logic [DATA_W-1:0] wbData
);
  logic [DATA_W-1:0] sizeBytes, stepped, baseAddr, offsetTerm, indexTerm, effAddr, nextValue;
  logic fire;

  assign fire       = reqValid && ctrl.legal;
  assign sizeBytes  = DATA_W'(1) << sizeSel;
  assign stepped    = ctrl.stepDown ? (rfData - sizeBytes) : (rfData + sizeBytes);
  assign baseAddr   = ctrl.stepDown ? stepped : rfData;
  assign offsetTerm = ctrl.addConst ? constVal : '0;
  assign indexTerm  = idxEn ? (idxVal << sizeSel) : '0;
  assign effAddr    = baseAddr + offsetTerm + indexTerm;

  always_comb begin
    if (ctrl.passConst)    nextValue = constVal;
    else if (ctrl.passReg) nextValue = rfData;
    else                   nextValue = effAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resValue <= '0;
      memRef   <= 1'b0;
      wbValid  <= 1'b0;
      wbReg    <= '0;
      wbData   <= '0;
    end else begin
      resValid <= fire;
      wbValid  <= fire && (ctrl.stepUp || ctrl.stepDown);
      if (fire) begin
        resValue <= nextValue;
        memRef   <= ctrl.memory;
        wbReg    <= regSel;
        wbData   <= stepped;
      end
    end
  end

  p_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ctrl.legal) |=> resValid);
  p_reserved_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && ctrl.legal) |=> (!resValid && !wbValid));
  p_wb_memory_r6: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (resValid && memRef));
  p_direct_nowb_r2: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !memRef) |-> !wbValid);
  p_post_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ctrl.stepUp && !idxEn) |=> (resValue == $past(rfData)));
endmodule

// File: rtl/opspec_agen.sv
module opspec_agen
  import opspec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        modeSel,
  input  logic [REG_W-1:0]  regSel,
  input  logic [DATA_W-1:0] constVal,
  input  logic [SIZE_W-1:0] sizeSel,
  input  logic              idxEn,
  input  logic [DATA_W-1:0] idxVal,
  output logic [REG_W-1:0]  rfAddr,
  input  logic [DATA_W-1:0] rfData,
  output logic              resValid,
  output logic [DATA_W-1:0] resValue,
  output logic              memRef,
  output logic              wbValid,
  output logic [REG_W-1:0]  wbReg,
  output logic [DATA_W-1:0] wbData
);
  specCtrl_t ctrl;

  assign rfAddr = regSel;

  opspec_ctrl i_ctrl (.modeSel(modeSel), .ctrl(ctrl));

  opspec_dp #(.DATA_W(DATA_W), .REG_W(REG_W), .SIZE_W(SIZE_W)) i_dp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ctrl(ctrl),
    .regSel(regSel), .rfData(rfData), .constVal(constVal),
    .sizeSel(sizeSel), .idxEn(idxEn), .idxVal(idxVal),
    .resValid(resValid), .resValue(resValue), .memRef(memRef),
    .wbValid(wbValid), .wbReg(wbReg), .wbData(wbData)
  );
endmodule

// File: tb/test_opspec_agen.sv
module test_opspec_agen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  modeSel = '0;
  logic [3:0]  regSel = '0;
  logic [31:0] constVal = '0;
  logic [1:0]  sizeSel = '0;
  logic        idxEn = 1'b0;
  logic [31:0] idxVal = '0;
  logic [3:0]  rfAddr;
  logic [31:0] rfData;
  logic        resValid, memRef, wbValid;
  logic [31:0] resValue, wbData;
  logic [3:0]  wbReg;
  logic [31:0] rf [16];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign rfData = rf[rfAddr];

  opspec_agen i_opspec_agen (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] m, input logic [3:0] r, input logic [31:0] c,
                       input logic [1:0] s, input logic ie, input logic [31:0] iv);
    @(negedge clk);
    reqValid = 1'b1; modeSel = m; regSel = r; constVal = c;
    sizeSel = s; idxEn = ie; idxVal = iv;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 resValid in reset", 32'(resValid), 0);
    chk("R1 wbValid in reset", 32'(wbValid), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1 resValid idle", 32'(resValid), 0);
    chk("R1 wbValid idle", 32'(wbValid), 0);
  endtask

  task automatic t_direct();
    issue(3'd0, 4'd3, 32'h5, 2'd2, 1'b1, 32'h7);
    chk("R2 value", resValue, rf[3]);
    chk("R2 memRef", 32'(memRef), 0);
    chk("R2 wb", 32'(wbValid), 0);
    chk("R9 index ignored in mode 0", resValue, rf[3]);
    issue(3'd1, 4'd3, 32'hCAFE_0001, 2'd3, 1'b1, 32'h7);
    chk("R3 value", resValue, 32'hCAFE_0001);
    chk("R3 memRef", 32'(memRef), 0);
    chk("R3 wb", 32'(wbValid), 0);
  endtask

  task automatic t_memory();
    issue(3'd2, 4'd5, 32'h40, 2'd0, 1'b0, 0);
    chk("R4 addr", resValue, rf[5]);
    chk("R4 memRef", 32'(memRef), 1);
    chk("R4 wb", 32'(wbValid), 0);
    issue(3'd3, 4'd6, 32'hFFFF_FFF0, 2'd1, 1'b0, 0);
    chk("R5 negative offset", resValue, rf[6] - 32'h10);
    chk("R5 wb", 32'(wbValid), 0);
    issue(3'd3, 4'd15, 32'h10, 2'd0, 1'b0, 0);
    chk("R5 wrap", resValue, 32'h0000_000F);
  endtask

  task automatic t_step();
    for (int s = 0; s < 4; s++) begin
      issue(3'd4, 4'd7, 0, 2'(s), 1'b0, 0);
      chk("R6 addr", resValue, rf[7]);
      chk("R6 wbValid", 32'(wbValid), 1);
      chk("R6 wbReg", 32'(wbReg), 7);
      chk("R8 post-step size", wbData, rf[7] + (32'd1 << s));
    end
    issue(3'd5, 4'd14, 0, 2'd2, 1'b0, 0);
    chk("R7 push addr", resValue, rf[14] - 4);
    chk("R7 push wbData", wbData, rf[14] - 4);
    chk("R7 push wbReg", 32'(wbReg), 14);
    chk("R7 push memRef", 32'(memRef), 1);
    issue(3'd4, 4'd14, 0, 2'd3, 1'b0, 0);
    chk("R7 pop addr", resValue, rf[14]);
    chk("R7 pop wbData", wbData, rf[14] + 8);
    issue(3'd5, 4'd2, 0, 2'd0, 1'b0, 0);
    chk("R8 pre-step size 1", resValue, rf[2] - 1);
  endtask

  task automatic t_index();
    for (int s = 0; s < 4; s++) begin
      issue(3'd3, 4'd4, 32'h20, 2'(s), 1'b1, 32'h3);
      chk("R9 offset+index", resValue, rf[4] + 32'h20 + (32'h3 << s));
    end
    issue(3'd5, 4'd8, 0, 2'd2, 1'b1, 32'h10);
    chk("R9 pre-step index addr", resValue, rf[8] - 4 + 32'h40);
    chk("R9 pre-step index wbData", wbData, rf[8] - 4);
    issue(3'd1, 4'd8, 32'h77, 2'd2, 1'b1, 32'h10);
    chk("R9 index ignored in mode 1", resValue, 32'h77);
  endtask

  task automatic t_reserved();
    for (int m = 6; m < 8; m++) begin
      issue(3'(m), 4'd3, 32'h1, 2'd0, 1'b0, 0);
      chk("R11 resValid", 32'(resValid), 0);
      chk("R11 wbValid", 32'(wbValid), 0);
    end
  endtask

  task automatic t_pipeline();
    @(negedge clk);
    reqValid = 1'b1; modeSel = 3'd4; regSel = 4'd9; sizeSel = 2'd2; idxEn = 1'b0;
    @(negedge clk);
    chk("R10 first result", resValue, rf[9]);
    chk("R10 first valid", 32'(resValid), 1);
    modeSel = 3'd1; constVal = 32'hABCD;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R10 second result", resValue, 32'hABCD);
    chk("R10 wb cleared", 32'(wbValid), 0);
    @(negedge clk);
    chk("R10 valid drops", 32'(resValid), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h1000_0000 + 32'(i) * 32'h100;
    rf[15] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    t_reset();
    t_direct();
    t_memory();
    t_step();
    t_index();
    t_reserved();
    t_pipeline();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule